// File: doc/BRIEF.md
# Parallel FIFO DMA request controller

This block sits between a byte-wide parallel port channel and a system DMA engine. It holds a byte FIFO of parameterised depth, tracks how many bytes the FIFO holds, and raises an active-low DMA request by comparing that count with a programmable threshold. The DMA side always moves 16-bit words, two bytes at a time, while the port side moves single bytes. A control register selects the transfer direction and the feature bits. A channel-local reset register and a flush bit return the channel to a clean state.

In the receive direction the port pushes bytes and DMA drains whole words. The request then asks for service once enough data has gathered. In the transmit direction DMA fills words and the port drains bytes. The request then asks for more data once the FIFO has run low. In transmit with run-length mode on, the two most recent bytes written over DMA stay in a pair of holding registers so that a codec can inspect them. Those bytes enter the FIFO only later, in order.

Top module: `pfifo_dma_ctl`

## Requirements
- R1: With rst_n low, the block clears the control register, the threshold register, the channel reset register, the FIFO count and both error flags, and holds dma_req_n high.
- R2: Register address 2 bit 0 is the channel reset. While it reads 1, the control register, the threshold and the FIFO stay cleared and dma_req_n stays high, and writes to addresses 0 and 1 are ignored. Once it is written back to 0, normal operation resumes.
- R3: The control register sits at address 0. Bit 6 enables DMA. Bit 5 selects the direction (1 = transmit, memory to FIFO; 0 = receive). Bit 3 enables run-length holding. Bit 0 is the DMA-buffer write enable. Bits 4, 2 and 1 are stored and read back. Bit 7 is a flush command and always reads back as 0.
- R4: A control write with bit 7 set empties the FIFO and the holding registers and clears both error flags. dma_req_n is high in the cycle after that write.
- R5: In receive, port_wr pushes port_wdata as one byte. dma_rd pops two bytes, and dma_rdata[7:0] carries the older of the two. dma_wr and port_rd have no effect.
- R6: In transmit with no bytes held, dma_wr pushes dma_wdata[7:0] first and then dma_wdata[15:8]. port_rd pops one byte, and port_rdata shows the oldest byte. port_wr and dma_rd have no effect.
- R7: level reports the number of bytes in the FIFO, from 0 to DEPTH. Held bytes are not counted.
- R8: A push that does not fit in the free space is dropped in full, and the sticky ovf flag is set.
- R9: A pop that asks for more bytes than the FIFO holds is dropped, and the sticky unf flag is set.
- R10: In receive with DMA enabled, dma_req_n is low exactly when level is greater than or equal to the threshold at address 1. The request is registered, so it follows level one cycle later.
- R11: In transmit with DMA enabled, dma_req_n is low exactly when level is less than or equal to the threshold. It is registered in the same way.
- R12: With DMA enable at 0, dma_req_n is high whatever the fill level.
- R13: In transmit with run-length mode on, each dma_wr moves any held bytes into the FIFO (older first) and places the new word in the holding registers. A write whose held bytes do not fit is dropped and sets ovf.
- R14: When the run-length, DMA enable and buffer write enable bits are all 0 in transmit, held bytes move into the FIFO one per cycle, older first, while space remains.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hard reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 threshold, 2 channel reset |
| reg_wdata | input | 8 | Register write data |
| ctrl_q | output | 8 | Control register contents |
| thr_q | output | 8 | Threshold register contents |
| chan_rst_q | output | 1 | Channel reset bit |
| level | output | $clog2(DEPTH)+1 | FIFO byte count |
| ovf | output | 1 | Sticky overflow flag |
| unf | output | 1 | Sticky underflow flag |
| port_wr | input | 1 | Port byte push (receive) |
| port_wdata | input | 8 | Port byte to push |
| port_rd | input | 1 | Port byte pop (transmit) |
| port_rdata | output | 8 | Oldest FIFO byte |
| dma_wr | input | 1 | DMA word write (transmit) |
| dma_wdata | input | 16 | DMA word, low byte first |
| dma_rd | input | 1 | DMA word read (receive) |
| dma_rdata | output | 16 | Two oldest FIFO bytes, oldest in the low byte |
| dma_req_n | output | 1 | Registered active-low DMA request |

## Verification
The assertions assume that software sets the direction only together with a flush, and that each direction's strobes are driven only while that direction is selected. A direction change without a flush could leave held bytes on the receive side. The stimulus meets this by starting every sweep with a control write that sets the flush bit and the direction together. The run-length checks run only in transmit. The sweeps cover every threshold against every reachable fill level in both directions, then drive one access past full and one past empty.

// File: rtl/pfifo_dma_ctl.sv
module pfifo_dma_ctl #(
  parameter int DEPTH = 32,
  localparam int AW = $clog2(DEPTH),
  localparam int LW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [1:0]    reg_addr,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    ctrl_q,
  output logic [7:0]    thr_q,
  output logic          chan_rst_q,
  output logic [LW-1:0] level,
  output logic          ovf,
  output logic          unf,
  input  logic          port_wr,
  input  logic [7:0]    port_wdata,
  input  logic          port_rd,
  output logic [7:0]    port_rdata,
  input  logic          dma_wr,
  input  logic [15:0]   dma_wdata,
  input  logic          dma_rd,
  output logic [15:0]   dma_rdata,
  output logic          dma_req_n
);

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [7:0]    hold0, hold1;
  logic [1:0]    hold_cnt;

  wire wr_ctrl = reg_wr && reg_addr == 2'd0 && !chan_rst_q;
  wire wr_thr  = reg_wr && reg_addr == 2'd1 && !chan_rst_q;
  wire wr_crr  = reg_wr && reg_addr == 2'd2;
  wire flush   = wr_ctrl && reg_wdata[7];

  wire dma_en = ctrl_q[6];
  wire tx     = ctrl_q[5];
  wire rle    = ctrl_q[3];
  wire buf_we = ctrl_q[0];

  assign port_rdata = mem[rptr];
  assign dma_rdata  = {mem[rptr + AW'(1)], mem[rptr]};

  logic [1:0] push_n, pop_n;
  logic [7:0] pb0, pb1;
  logic       set_ovf, set_unf, hold_ld, hold_shift;

  always_comb begin
    push_n = 2'd0;
    pop_n = 2'd0;
    pb0 = 8'd0;
    pb1 = 8'd0;
    set_ovf = 1'b0;
    set_unf = 1'b0;
    hold_ld = 1'b0;
    hold_shift = 1'b0;
    if (tx) begin
      if (dma_wr) begin
        if (rle || hold_cnt != 2'd0) begin
          if (int'(level) + int'(hold_cnt) > DEPTH) set_ovf = 1'b1;
          else begin
            push_n = hold_cnt;
            pb0 = hold0;
            pb1 = hold1;
            hold_ld = 1'b1;
          end
        end else if (int'(level) + 2 > DEPTH) set_ovf = 1'b1;
        else begin
          push_n = 2'd2;
          pb0 = dma_wdata[7:0];
          pb1 = dma_wdata[15:8];
        end
      end else if (!rle && !dma_en && !buf_we && hold_cnt != 2'd0 && int'(level) < DEPTH) begin
        push_n = 2'd1;
        pb0 = hold0;
        hold_shift = 1'b1;
      end
      if (port_rd) begin
        if (level == '0) set_unf = 1'b1;
        else pop_n = 2'd1;
      end
    end else begin
      if (port_wr) begin
        if (int'(level) >= DEPTH) set_ovf = 1'b1;
        else begin
          push_n = 2'd1;
          pb0 = port_wdata;
        end
      end
      if (dma_rd) begin
        if (int'(level) < 2) set_unf = 1'b1;
        else pop_n = 2'd2;
      end
    end
  end

  wire thr_hit = tx ? (int'(level) <= int'(thr_q)) : (int'(level) >= int'(thr_q));

  always_ff @(posedge clk) begin
    if (push_n != 2'd0) mem[wptr] <= pb0;
    if (push_n == 2'd2) mem[wptr + AW'(1)] <= pb1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chan_rst_q <= 1'b0;
    else if (wr_crr) chan_rst_q <= reg_wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      thr_q <= '0;
      wptr <= '0;
      rptr <= '0;
      level <= '0;
      ovf <= 1'b0;
      unf <= 1'b0;
      hold0 <= '0;
      hold1 <= '0;
      hold_cnt <= '0;
      dma_req_n <= 1'b1;
    end else if (chan_rst_q) begin
      ctrl_q <= '0;
      thr_q <= '0;
      wptr <= '0;
      rptr <= '0;
      level <= '0;
      ovf <= 1'b0;
      unf <= 1'b0;
      hold_cnt <= '0;
      dma_req_n <= 1'b1;
    end else begin
      if (wr_ctrl) ctrl_q <= {1'b0, reg_wdata[6:0]};
      if (wr_thr) thr_q <= reg_wdata;
      dma_req_n <= !(dma_en && !flush && thr_hit);
      if (flush) begin
        wptr <= '0;
        rptr <= '0;
        level <= '0;
        ovf <= 1'b0;
        unf <= 1'b0;
        hold_cnt <= '0;
      end else begin
        wptr <= wptr + AW'(push_n);
        rptr <= rptr + AW'(pop_n);
        level <= level + LW'(push_n) - LW'(pop_n);
        if (set_ovf) ovf <= 1'b1;
        if (set_unf) unf <= 1'b1;
        if (hold_ld) begin
          hold0 <= dma_wdata[7:0];
          hold1 <= dma_wdata[15:8];
          hold_cnt <= 2'd2;
        end else if (hold_shift) begin
          hold0 <= hold1;
          hold_cnt <= hold_cnt - 2'd1;
        end
      end
    end
  end

  a_r7_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    int'(level) <= DEPTH);

  a_r2_chan_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
    chan_rst_q |=> (ctrl_q == 8'd0 && level == '0 && dma_req_n));

  a_r4_flush_empties: assert property (@(posedge clk) disable iff (!rst_n || chan_rst_q)
    flush |=> (level == '0 && !ovf && !unf && dma_req_n));

  a_r12_req_off_disabled: assert property (@(posedge clk) disable iff (!rst_n || chan_rst_q)
    !dma_en |=> dma_req_n);

  a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n || chan_rst_q)
    (ovf && !flush) |=> ovf);

  a_r9_unf_sticky: assert property (@(posedge clk) disable iff (!rst_n || chan_rst_q)
    (unf && !flush) |=> unf);

  a_r5_rx_idle_stable: assert property (@(posedge clk) disable iff (!rst_n || chan_rst_q)
    (!tx && !port_wr && !dma_rd && !flush) |=> $stable(level));

  a_r13_hold_bound: assert property (@(posedge clk) disable iff (!rst_n)
    hold_cnt <= 2'd2);

endmodule

// File: tb/tb_pfifo_dma_ctl.sv
module tb_pfifo_dma_ctl;
  localparam int DEPTH = 32;
  localparam int LW = $clog2(DEPTH) + 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] ctrl_q, thr_q;
  logic chan_rst_q;
  logic [LW-1:0] level;
  logic ovf, unf;
  logic port_wr = 1'b0, port_rd = 1'b0, dma_wr = 1'b0, dma_rd = 1'b0;
  logic [7:0] port_wdata = '0, port_rdata;
  logic [15:0] dma_wdata = '0, dma_rdata;
  logic dma_req_n;

  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pfifo_dma_ctl #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .ctrl_q(ctrl_q), .thr_q(thr_q), .chan_rst_q(chan_rst_q), .level(level), .ovf(ovf), .unf(unf),
    .port_wr(port_wr), .port_wdata(port_wdata), .port_rd(port_rd), .port_rdata(port_rdata),
    .dma_wr(dma_wr), .dma_wdata(dma_wdata), .dma_rd(dma_rd), .dma_rdata(dma_rdata),
    .dma_req_n(dma_req_n));

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick(int n = 1);
    repeat (n) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic wr_reg(int a, int d);
    reg_wr = 1'b1; reg_addr = 2'(a); reg_wdata = 8'(d);
    tick();
    reg_wr = 1'b0;
  endtask

  function automatic int rxb(int k);
    return (k * 37 + 11) & 255;
  endfunction

  function automatic int txw(int k);
    return (k * 4513 + 291) & 16'hffff;
  endfunction

  task automatic push_port(int d);
    port_wr = 1'b1; port_wdata = 8'(d);
    tick();
    port_wr = 1'b0;
  endtask

  task automatic push_dma(int d);
    dma_wr = 1'b1; dma_wdata = 16'(d);
    tick();
    dma_wr = 1'b0;
  endtask

  task automatic pop_dma();
    dma_rd = 1'b1;
    tick();
    dma_rd = 1'b0;
  endtask

  task automatic pop_port();
    port_rd = 1'b1;
    tick();
    port_rd = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    tick(3);
    chk("R1 ctrl", ctrl_q, 0);
    chk("R1 thr", thr_q, 0);
    chk("R1 level", level, 0);
    chk("R1 req", dma_req_n, 1);
    chk("R1 flags", {ovf, unf}, 0);
    rst_n = 1'b1;
    tick(2);

    wr_reg(0, 8'hFF);
    chk("R3 flush bit reads 0", ctrl_q, 8'h7F);
    wr_reg(0, 8'h96);
    chk("R3 stored bits", ctrl_q, 8'h16);

    // R10 receive sweep, R5 data, R8/R9 limits
    for (int t = 0; t <= DEPTH; t++) begin
      wr_reg(1, t);
      wr_reg(0, 8'hC0);
      tick();
      for (int k = 0; k <= DEPTH; k++) begin
        tick();
        chk("R7 rx level", level, k);
        chk("R10 rx req", dma_req_n, (k >= t) ? 0 : 1);
        if (k < DEPTH) push_port(rxb(k));
      end
      if (t == 3) begin
        push_dma(16'h1234);
        port_rd = 1'b1; tick(); port_rd = 1'b0;
        chk("R5 rx ignores tx strobes", level, DEPTH);
        chk("R5 no flag", {ovf, unf}, 0);
      end
      push_port(8'hAA);
      chk("R8 rx overflow level", level, DEPTH);
      chk("R8 rx ovf", ovf, 1);
      for (int j = 0; j < DEPTH / 2; j++) begin
        chk("R5 rx word", dma_rdata, (rxb(2 * j + 1) << 8) | rxb(2 * j));
        pop_dma();
      end
      chk("R5 rx empty", level, 0);
      push_port(8'h55);
      pop_dma();
      chk("R9 rx underflow level", level, 1);
      chk("R9 rx unf", unf, 1);
    end

    // R11 transmit sweep, R6 data
    for (int t = 0; t <= DEPTH; t++) begin
      wr_reg(1, t);
      wr_reg(0, 8'hE0);
      tick();
      for (int w = 0; w <= DEPTH / 2; w++) begin
        tick();
        chk("R7 tx level", level, 2 * w);
        chk("R11 tx req", dma_req_n, (2 * w <= t) ? 0 : 1);
        if (w < DEPTH / 2) push_dma(txw(w));
      end
      if (t == 5) begin
        push_port(8'h77);
        pop_dma();
        chk("R6 tx ignores rx strobes", level, DEPTH);
      end
      push_dma(16'hBEEF);
      chk("R8 tx overflow level", level, DEPTH);
      chk("R8 tx ovf", ovf, 1);
      for (int b = 0; b < DEPTH; b++) begin
        chk("R6 tx byte", port_rdata, (b % 2) ? (txw(b / 2) >> 8) : (txw(b / 2) & 255));
        pop_port();
      end
      pop_port();
      chk("R9 tx underflow level", level, 0);
      chk("R9 tx unf", unf, 1);
    end

    // R12 disabled request while level meets threshold
    wr_reg(1, 0);
    wr_reg(0, 8'h80);
    push_port(1); push_port(2);
    tick(3);
    chk("R12 req off", dma_req_n, 1);

    // R4 flush from a non-empty flagged state
    pop_dma(); pop_dma();
    chk("R4 pre unf", unf, 1);
    wr_reg(0, 8'h80);
    chk("R4 level", level, 0);
    chk("R4 flags", {ovf, unf}, 0);

    // R2 channel reset
    wr_reg(1, 8);
    wr_reg(0, 8'hC0);
    push_port(9);
    wr_reg(2, 1);
    tick(2);
    chk("R2 ctrl", ctrl_q, 0);
    chk("R2 thr", thr_q, 0);
    chk("R2 level", level, 0);
    wr_reg(0, 8'h45);
    tick();
    chk("R2 write ignored", ctrl_q, 0);
    chk("R2 req", dma_req_n, 1);
    wr_reg(2, 0);
    wr_reg(0, 8'h45);
    chk("R2 resumes", ctrl_q, 8'h45);

    // R13/R14 run-length holding
    wr_reg(0, 8'hE8);
    push_dma(16'h1101);
    tick();
    chk("R13 first word held", level, 0);
    push_dma(16'h2202);
    chk("R13 second write", level, 2);
    push_dma(16'h3303);
    chk("R13 third write", level, 4);
    wr_reg(0, 8'h29);
    tick(4);
    chk("R14 rle on keeps", level, 4);
    wr_reg(0, 8'h21);
    tick(4);
    chk("R14 buf_we keeps", level, 4);
    wr_reg(0, 8'h20);
    tick(4);
    chk("R14 released", level, 6);
    begin
      int exp_b[6] = '{8'h01, 8'h11, 8'h02, 8'h22, 8'h03, 8'h33};
      for (int b = 0; b < 6; b++) begin
        chk("R14 order", port_rdata, exp_b[b]);
        pop_port();
      end
    end
    chk("R14 drained", level, 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule